// File: doc/BRIEF.md
# Group-Remapped Direct-Mapped Cache Lookup

This block is the tag and index lookup path of a direct-mapped cache whose line selection has been made partly programmable, so that hot addresses that would otherwise fight over one line can be spread onto idle lines. The incoming line address (byte offset already stripped) is split into three fields. A fixed group field picks one group of eight lines. A programmable field is compared in parallel with a rewritable decoder word held by each line of that group. A tag field is then checked against the one line whose decoder word matched. Because at most one line per group can match, a lookup costs a single direct-mapped probe. The response, one cycle later, is hit or miss plus the number of the selected line, which stands in for the data array.

On a miss the surrounding controller presents the same line address as a fill. If some line of the group already carries that decoder word, that line is reused and only its tag changes. Otherwise an invalid line of the group is taken, or, when the group is full, a victim chosen by the replacement policy. The policy is a parameter: least-recently-used by age order per group, or pseudo-random from a free-running LFSR. With the default sizes (64 groups of 8 lines, 6-bit programmable field, 15-bit tag) this is a 16 kB cache of 32-byte lines.

Top module: `pdc_cache`

## Requirements
- R1: The line address is split as group = bits [5:0], programmable field = bits [11:6], tag = bits [26:12]; a hit reports line number group*8 + way.
- R2: After reset every line is invalid, rsp_valid is low, and every lookup misses.
- R3: A lookup accepted in one cycle gives rsp_valid high in the next cycle; with no accepted lookup rsp_valid is low; a miss reports line number 0.
- R4: A lookup hits only if a valid line of the addressed group holds the same programmable field and the same tag; the same fields in another group miss.
- R5: A fill whose programmable field matches a valid line of its group rewrites only that line's tag, so the old tag then misses and the new tag hits on the same line.
- R6: A fill with no decoder match in its group takes the lowest-numbered invalid way.
- R7: With the group full, a non-matching fill replaces the way least recently hit or filled (default policy); the alternative policy takes the way from a free-running LFSR.
- R8: No group ever holds two valid lines with the same programmable field.
- R9: When fill_valid and req_valid are high in the same cycle the fill is performed and the lookup is dropped (rsp_valid low next cycle).
- R10: A lookup issued the cycle after a fill of the same line address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_lad | input | 27 | Line address of the lookup |
| fill_valid | input | 1 | Fill request |
| fill_lad | input | 27 | Line address to install |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_line | output | 9 | Selected line on hit, 0 on miss |

## Verification
Lookups are tried against an empty cache, against lines sharing a group but differing in decoder word, against identical decoder word and tag in a different group, and against a decoder match whose tag differs, which separates group selection, decoder matching and tag checking. Fill patterns cover a reused decoder word, an empty way and a full group; the full-group case, after a chosen order of hits and fills, tells true age order apart from any fixed or index-based pick. Simultaneous fill and lookup, a mid-run reset, and the top group number check precedence, clearing and the line numbering.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {POL_LRU = 1'b0, POL_RAND = 1'b1} policy_e;
endpackage

// File: rtl/pdc_match.sv
module pdc_match #(
  parameter int PI_W  = 6,
  parameter int TAG_W = 15,
  parameter int WAYS  = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][PI_W-1:0]   way_pd,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [PI_W-1:0]             key_pi,
  input  logic [TAG_W-1:0]            key_tag,
  output logic                        pd_hit,
  output logic [WAY_W-1:0]            pd_way,
  output logic                        tag_hit,
  output logic                        free_any,
  output logic [WAY_W-1:0]            free_way
);
  logic [WAYS-1:0] pd_vec;

  // parallel compare of every decoder word in the group
  always_comb begin
    for (int w = 0; w < WAYS; w++) pd_vec[w] = way_vld[w] && (way_pd[w] == key_pi);
  end

  // encoders, lowest index wins
  always_comb begin
    pd_way   = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pd_vec[w])   pd_way   = WAY_W'(w);
      if (!way_vld[w]) free_way = WAY_W'(w);
    end
  end

  assign pd_hit   = |pd_vec;
  assign free_any = ~&way_vld;
  assign tag_hit  = pd_hit && (way_tag[pd_way] == key_tag);

  AST_ONE_PD_MATCH: assert property (@(posedge clk) disable iff (rst) $countones(pd_vec) <= 1); // R8
endmodule

// File: rtl/pdc_victim.sv
module pdc_victim
  import pdc_pkg::*;
#(
  parameter policy_e POLICY = POL_LRU,
  parameter int GRP_W = 6,
  parameter int WAYS  = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int GROUPS = 1 << GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [GRP_W-1:0] touch_grp,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [GRP_W-1:0] sel_grp,
  output logic [WAY_W-1:0] pick_way
);
  generate
    if (POLICY == POL_LRU) begin : g_lru
      // age 0 = most recent, WAYS-1 = oldest; each group holds a permutation
      logic [WAYS-1:0][WAY_W-1:0] age [GROUPS];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int g = 0; g < GROUPS; g++)
            for (int w = 0; w < WAYS; w++) age[g][w] <= WAY_W'(w);
        end else if (touch_en) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
              age[touch_grp][w] <= '0;
            else if (age[touch_grp][w] < age[touch_grp][touch_way])
              age[touch_grp][w] <= age[touch_grp][w] + 1'b1;
          end
        end
      end

      always_comb begin
        pick_way = '0;
        for (int w = 0; w < WAYS; w++)
          if (age[sel_grp][w] == WAY_W'(WAYS - 1)) pick_way = WAY_W'(w);
      end

      AST_LRU_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> age[$past(touch_grp)][$past(touch_way)] == '0); // R7
    end else begin : g_rand
      logic [7:0] lfsr;

      always_ff @(posedge clk) begin
        if (rst) lfsr <= 8'h01;
        else     lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end

      assign pick_way = lfsr[WAY_W-1:0];

      AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst) lfsr != 8'h00); // R7
    end
  endgenerate
endmodule

// File: rtl/pdc_cache.sv
module pdc_cache
  import pdc_pkg::*;
#(
  parameter int TAG_W = 15,
  parameter int PI_W  = 6,
  parameter int GRP_W = 6,
  parameter int WAYS  = 8,
  parameter policy_e POLICY = POL_LRU,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = GRP_W + WAY_W,
  localparam int LINES  = 1 << LINE_W,
  localparam int LAD_W  = TAG_W + PI_W + GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LAD_W-1:0]  req_lad,
  input  logic              fill_valid,
  input  logic [LAD_W-1:0]  fill_lad,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_line
);
  // line state: valid bits reset, decoder words and tags kept in plain arrays
  logic [LINES-1:0] vld;
  logic [PI_W-1:0]  pd_mem  [LINES];
  logic [TAG_W-1:0] tag_mem [LINES];

  logic [GRP_W-1:0] l_grp, f_grp;
  logic [PI_W-1:0]  l_pi,  f_pi;
  logic [TAG_W-1:0] l_tag, f_tag;
  assign {l_tag, l_pi, l_grp} = req_lad;
  assign {f_tag, f_pi, f_grp} = fill_lad;

  logic [WAYS-1:0]            l_vld, f_vld;
  logic [WAYS-1:0][PI_W-1:0]  l_pd,  f_pd;
  logic [WAYS-1:0][TAG_W-1:0] l_tg,  f_tg;

  for (genvar w = 0; w < WAYS; w++) begin : g_gather
    assign l_vld[w] = vld[{l_grp, WAY_W'(w)}];
    assign l_pd[w]  = pd_mem[{l_grp, WAY_W'(w)}];
    assign l_tg[w]  = tag_mem[{l_grp, WAY_W'(w)}];
    assign f_vld[w] = vld[{f_grp, WAY_W'(w)}];
    assign f_pd[w]  = pd_mem[{f_grp, WAY_W'(w)}];
    assign f_tg[w]  = tag_mem[{f_grp, WAY_W'(w)}];
  end

  logic             l_pdhit, l_hit, l_free;
  logic [WAY_W-1:0] l_way, l_fway;
  logic             f_pdhit, f_taghit, f_free;
  logic [WAY_W-1:0] f_pdway, f_fway, pol_way, f_way;

  pdc_match #(.PI_W(PI_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_lookup (
    .clk(clk), .rst(rst), .way_vld(l_vld), .way_pd(l_pd), .way_tag(l_tg),
    .key_pi(l_pi), .key_tag(l_tag), .pd_hit(l_pdhit), .pd_way(l_way),
    .tag_hit(l_hit), .free_any(l_free), .free_way(l_fway));

  pdc_match #(.PI_W(PI_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_fillsel (
    .clk(clk), .rst(rst), .way_vld(f_vld), .way_pd(f_pd), .way_tag(f_tg),
    .key_pi(f_pi), .key_tag(f_tag), .pd_hit(f_pdhit), .pd_way(f_pdway),
    .tag_hit(f_taghit), .free_any(f_free), .free_way(f_fway));

  logic req_fire, touch_en;
  assign req_fire = req_valid && !fill_valid;
  assign touch_en = fill_valid || (req_fire && l_hit);

  pdc_victim #(.POLICY(POLICY), .GRP_W(GRP_W), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst(rst), .touch_en(touch_en),
    .touch_grp(fill_valid ? f_grp : l_grp),
    .touch_way(fill_valid ? f_way : l_way),
    .sel_grp(f_grp), .pick_way(pol_way));

  // reuse a decoder match, else an empty way, else the policy's choice
  always_comb begin
    if (f_pdhit)     f_way = f_pdway;
    else if (f_free) f_way = f_fway;
    else             f_way = pol_way;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (fill_valid) vld[{f_grp, f_way}] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      pd_mem[{f_grp, f_way}]  <= f_pi;
      tag_mem[{f_grp, f_way}] <= f_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= req_fire;
      rsp_hit   <= req_fire && l_hit;
      rsp_line  <= (req_fire && l_hit) ? {l_grp, l_way} : '0;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !fill_valid) |=> rsp_valid); // R3
  AST_FILL_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !rsp_valid); // R9
  AST_MISS_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> rsp_line == '0); // R3
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !req_valid) ##1 (req_valid && !fill_valid && req_lad == $past(fill_lad)) |=> rsp_hit); // R10
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid); // R4
endmodule

// File: tb/pdc_cache_bench.sv
`timescale 1ns/1ps
module pdc_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [26:0] req_lad = '0;
  logic        fill_valid = 1'b0;
  logic [26:0] fill_lad = '0;
  logic        rsp_valid, rsp_hit;
  logic [8:0]  rsp_line;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pdc_cache u_pdc_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lad(req_lad),
    .fill_valid(fill_valid), .fill_lad(fill_lad),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_line(rsp_line));

  // R1 layout: tag [26:12], programmable field [11:6], group [5:0]
  function automatic logic [26:0] mk(int tg, int pi, int grp);
    return {tg[14:0], pi[5:0], grp[5:0]};
  endfunction

  // row: {is_fill, line address, expected hit, expected line, requirement}
  localparam int N = 29;
  localparam logic [41:0] TBL [N] = '{
    {1'b0, mk(1,5,3),   1'b0, 9'd0,   4'd2},  // R2 empty cache misses
    {1'b1, mk(1,5,3),   1'b0, 9'd0,   4'd6},
    {1'b0, mk(1,5,3),   1'b1, 9'd24,  4'd10}, // R10 way 0 of group 3
    {1'b1, mk(2,6,3),   1'b0, 9'd0,   4'd6},
    {1'b0, mk(2,6,3),   1'b1, 9'd25,  4'd6},  // R6 next invalid way
    {1'b0, mk(1,5,3),   1'b1, 9'd24,  4'd4},
    {1'b0, mk(1,5,4),   1'b0, 9'd0,   4'd4},  // R4 other group
    {1'b0, mk(1,6,3),   1'b0, 9'd0,   4'd4},  // R4 decoder hit, tag differs
    {1'b1, mk(7,5,3),   1'b0, 9'd0,   4'd5},
    {1'b0, mk(7,5,3),   1'b1, 9'd24,  4'd5},  // R5 tag replaced in place
    {1'b0, mk(1,5,3),   1'b0, 9'd0,   4'd8},  // R8 no second copy of field 5
    {1'b1, mk(9,10,3),  1'b0, 9'd0,   4'd6},
    {1'b1, mk(9,11,3),  1'b0, 9'd0,   4'd6},
    {1'b1, mk(9,12,3),  1'b0, 9'd0,   4'd6},
    {1'b1, mk(9,13,3),  1'b0, 9'd0,   4'd6},
    {1'b1, mk(9,14,3),  1'b0, 9'd0,   4'd6},
    {1'b1, mk(9,15,3),  1'b0, 9'd0,   4'd6},
    {1'b0, mk(9,15,3),  1'b1, 9'd31,  4'd6},
    {1'b1, mk(3,20,3),  1'b0, 9'd0,   4'd7},  // R7 oldest is way 1
    {1'b0, mk(2,6,3),   1'b0, 9'd0,   4'd7},
    {1'b0, mk(3,20,3),  1'b1, 9'd25,  4'd7},
    {1'b0, mk(9,10,3),  1'b1, 9'd26,  4'd7},  // hit refreshes way 2
    {1'b1, mk(4,21,3),  1'b0, 9'd0,   4'd7},  // R7 oldest is now way 0
    {1'b0, mk(7,5,3),   1'b0, 9'd0,   4'd7},
    {1'b0, mk(4,21,3),  1'b1, 9'd24,  4'd7},
    {1'b0, mk(9,11,3),  1'b1, 9'd27,  4'd1},
    {1'b1, mk(5,0,63),  1'b0, 9'd0,   4'd1},
    {1'b0, mk(5,0,63),  1'b1, 9'd504, 4'd1},  // R1 group 63 way 0
    {1'b0, mk(5,0,62),  1'b0, 9'd0,   4'd3}   // R3 miss reports line 0
  };

  task automatic chk(int rq, logic v_e, logic h_e, logic [8:0] l_e);
    checks++;
    if (rsp_valid !== v_e || rsp_hit !== h_e || rsp_line !== l_e) begin
      errors++;
      $display("FAIL R%0d: valid=%0b hit=%0b line=%0d expected valid=%0b hit=%0b line=%0d",
               rq, rsp_valid, rsp_hit, rsp_line, v_e, h_e, l_e);
    end
  endtask

  task automatic do_fill(logic [26:0] a);
    @(negedge clk); fill_valid = 1'b1; fill_lad = a;
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic do_look(logic [26:0] a, int rq, logic h_e, logic [8:0] l_e);
    @(negedge clk); req_valid = 1'b1; req_lad = a;
    @(negedge clk); req_valid = 1'b0;
    chk(rq, 1'b1, h_e, l_e);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(2, 1'b0, 1'b0, 9'd0);                  // R2 reset state
    for (int i = 0; i < N; i++) begin
      if (TBL[i][41]) do_fill(TBL[i][40:14]);
      else            do_look(TBL[i][40:14], int'(TBL[i][3:0]), TBL[i][13], TBL[i][12:4]);
    end
    @(negedge clk);
    chk(3, 1'b0, 1'b0, 9'd0);                  // R3 idle cycle gives no response
    // R9: fill and lookup together, lookup dropped, fill done
    @(negedge clk);
    req_valid = 1'b1; req_lad = mk(5,0,63);
    fill_valid = 1'b1; fill_lad = mk(6,1,63);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    chk(9, 1'b0, 1'b0, 9'd0);
    do_look(mk(6,1,63), 9, 1'b1, 9'd505);      // R9 fill took way 1
    // R2 mid-run reset clears every line
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(2, 1'b0, 1'b0, 9'd0);
    do_look(mk(4,21,3), 2, 1'b0, 9'd0);
    do_look(mk(6,1,63), 2, 1'b0, 9'd0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end
endmodule